// File: doc/BRIEF.md
# Colour Lookup Table Host Port

This block holds a 256-entry colour table with 8 bits per red, green and blue component. It gives a host access to the table through four byte-wide lanes of one register word. The lanes are a write index, a read index, a pixel mask and a data port. A colour moves through the data port as three byte accesses in a row: red first, then green, then blue. One three-phase component counter is shared by reads and writes. The write index advances by one after each completed triplet that is written, and the read index advances by one after each completed triplet that is read. Both indices wrap from 255 to 0.

Each data-port write is ANDed with the mask before it is held. A triplet reaches the table only when its third component arrives. A data-port read at phase 0 captures the whole entry, so the three bytes that follow come from a single snapshot of that entry. A second, independent read port feeds the pixel path: it looks up the entry at a pixel index and presents the 24-bit colour one clock later.

Top module: `clut_host_port`

## Requirements
- R1: After reset the write index, the read index and the component counter are 0, the mask is 0xFF, and `rdata_o` is 0.
- R2: Lane encoding on `lane_i`: 0 is the write index, 1 is data, 2 is the mask, 3 is the read index. Reads of lanes 0, 2 and 3 return the stored value and change no state. A cycle with `req_i` low changes no state.
- R3: A write to lane 0 or to lane 3 returns the component counter to 0, so the next data access is the red component.
- R4: Each data write stores `wdata_i & mask` into the slot selected by the counter, in the order red, green, blue. On the third write the triplet goes to the table at the write index. The mask in force at each write is the one applied.
- R5: After each committed triplet the write index increments by one, wrapping from 255 to 0.
- R6: A data read at counter 0 captures the table entry at the read index. Each data read returns the red, green or blue byte selected by the counter. `rdata_o` is registered and is valid one clock after the read.
- R7: After the third data read the read index increments by one, wrapping from 255 to 0, and the counter returns to 0.
- R8: `pix_rgb_o` shows the entry at `pix_idx_i` one clock later, with red in bits 23:16, green in 15:8 and blue in 7:0. Host traffic does not affect this port.
- R9: A triplet that is cut off by an index write before its third component leaves the table entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access strobe, one access per cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| lane_i | input | 2 | Byte lane select (see R2) |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read byte, registered |
| pix_idx_i | input | 8 | Pixel lookup index |
| pix_rgb_o | output | 24 | Looked-up colour, registered |

## Verification
The table is loaded with triplets whose components are all different. This shows whether components are swapped between red, green and blue, or whether entries are placed at the wrong index. Entries are read back both through the data port and through the pixel port. A narrow mask followed by all-ones data separates masking on write from masking on read. The counter is reset in the middle of a triplet, once with the write index and once with the read index. This checks that the counter is shared and that an incomplete triplet never reaches the table. The indices are placed at 255 to check the wrap to 0.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int COMP_W = 8;

  typedef enum logic [1:0] {
    LANE_WIDX = 2'd0,
    LANE_DATA = 2'd1,
    LANE_MASK = 2'd2,
    LANE_RIDX = 2'd3
  } lane_e;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/clut_ram.sv
module clut_ram
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  rgb_t             wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  output rgb_t             rdata_a_o,
  input  logic [IDX_W-1:0] raddr_b_i,
  output rgb_t             rdata_b_o
);
  localparam int DEPTH = 1 << IDX_W;

  rgb_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/clut_phase.sv
module clut_phase #(
  parameter int STEPS = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     step_i,
  output logic [$clog2(STEPS)-1:0] phase_o,
  output logic                     last_o
);
  localparam int PW = $clog2(STEPS);
  localparam logic [PW-1:0] LAST = PW'(STEPS - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= '0;
    else if (clr_i)             phase_q <= '0;
    else if (step_i && last_o)  phase_q <= '0;
    else if (step_i)            phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;
  assign last_o  = (phase_q == LAST);
endmodule

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  lane_e             lane_i,
  input  logic [COMP_W-1:0] wdata_i,
  output logic [COMP_W-1:0] rdata_o,
  input  rgb_t              ram_rd_i,
  output logic [IDX_W-1:0]  ram_raddr_o,
  output logic              ram_we_o,
  output logic [IDX_W-1:0]  ram_waddr_o,
  output rgb_t              ram_wdata_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [1:0]        phase_o,
  output logic [COMP_W-1:0] mask_o
);
  localparam int NHOLD = 2;

  logic [IDX_W-1:0]  wr_idx_q, rd_idx_q;
  logic [COMP_W-1:0] mask_q, rdata_q;
  logic [COMP_W-1:0] hold_q [NHOLD];
  rgb_t              snap_q, entry;
  logic [1:0]        phase;
  logic              last;
  logic              wr_acc, rd_acc, idx_wr, dat_wr, dat_rd;
  logic [COMP_W-1:0] masked, comp;

  assign wr_acc = req_i && we_i;
  assign rd_acc = req_i && !we_i;
  assign idx_wr = wr_acc && (lane_i == LANE_WIDX || lane_i == LANE_RIDX);
  assign dat_wr = wr_acc && lane_i == LANE_DATA;
  assign dat_rd = rd_acc && lane_i == LANE_DATA;
  assign masked = wdata_i & mask_q;

  clut_phase #(.STEPS(3)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (idx_wr),
    .step_i (dat_wr || dat_rd),
    .phase_o(phase),
    .last_o (last)
  );

  // phase 0 reads straight from the table, later phases from the snapshot
  assign entry = (phase == 2'd0) ? ram_rd_i : snap_q;

  always_comb begin
    unique case (phase)
      2'd0:    comp = entry.r;
      2'd1:    comp = entry.g;
      default: comp = entry.b;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      mask_q   <= '1;
      rdata_q  <= '0;
      snap_q   <= '0;
      for (int i = 0; i < NHOLD; i++) hold_q[i] <= '0;
    end else begin
      if (wr_acc && lane_i == LANE_WIDX) wr_idx_q <= wdata_i[IDX_W-1:0];
      if (wr_acc && lane_i == LANE_RIDX) rd_idx_q <= wdata_i[IDX_W-1:0];
      if (wr_acc && lane_i == LANE_MASK) mask_q   <= wdata_i;
      if (dat_wr && !last) hold_q[phase[0]] <= masked;
      if (dat_wr && last)  wr_idx_q <= wr_idx_q + 1'b1;
      if (dat_rd && phase == 2'd0) snap_q <= ram_rd_i;
      if (dat_rd && last)  rd_idx_q <= rd_idx_q + 1'b1;
      if (rd_acc) begin
        unique case (lane_i)
          LANE_WIDX: rdata_q <= COMP_W'(wr_idx_q);
          LANE_DATA: rdata_q <= comp;
          LANE_MASK: rdata_q <= mask_q;
          default:   rdata_q <= COMP_W'(rd_idx_q);
        endcase
      end
    end
  end

  assign ram_raddr_o   = rd_idx_q;
  assign ram_we_o      = dat_wr && last;
  assign ram_waddr_o   = wr_idx_q;
  assign ram_wdata_o.r = hold_q[0];
  assign ram_wdata_o.g = hold_q[1];
  assign ram_wdata_o.b = masked;

  assign rdata_o  = rdata_q;
  assign wr_idx_o = wr_idx_q;
  assign rd_idx_o = rd_idx_q;
  assign phase_o  = phase;
  assign mask_o   = mask_q;
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        lane_i,
  input  logic [COMP_W-1:0] wdata_i,
  output logic [COMP_W-1:0] rdata_o,
  input  logic [IDX_W-1:0]  pix_idx_i,
  output logic [3*COMP_W-1:0] pix_rgb_o
);
  rgb_t             ram_rd, ram_wdata, pix_rd, pix_q;
  logic [IDX_W-1:0] ram_raddr, ram_waddr;
  logic             ram_we;
  logic [IDX_W-1:0] wr_idx_w, rd_idx_w;
  logic [1:0]       phase_w;
  logic [COMP_W-1:0] mask_w;

  clut_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .lane_i     (lane_e'(lane_i)),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .ram_rd_i   (ram_rd),
    .ram_raddr_o(ram_raddr),
    .ram_we_o   (ram_we),
    .ram_waddr_o(ram_waddr),
    .ram_wdata_o(ram_wdata),
    .wr_idx_o   (wr_idx_w),
    .rd_idx_o   (rd_idx_w),
    .phase_o    (phase_w),
    .mask_o     (mask_w)
  );

  clut_ram #(.IDX_W(IDX_W)) u_ram (
    .clk_i    (clk_i),
    .we_i     (ram_we),
    .waddr_i  (ram_waddr),
    .wdata_i  (ram_wdata),
    .raddr_a_i(ram_raddr),
    .rdata_a_o(ram_rd),
    .raddr_b_i(pix_idx_i),
    .rdata_b_o(pix_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_q <= '0;
    else         pix_q <= pix_rd;
  end

  assign pix_rgb_o = pix_q;
endmodule

// File: rtl/clut_host_port_chk.sv
module clut_host_port_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       lane_i,
  input logic [7:0]       wdata_i,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] rd_idx,
  input logic [1:0]       phase,
  input logic [7:0]       mask
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  a_r3_idx_clears_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (lane_i == 2'd0 || lane_i == 2'd3)) |=> phase == 2'd0);

  a_r4_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase != 2'd3);

  a_r5_wr_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && lane_i == 2'd1 && phase == 2'd2) |=> wr_idx == $past(wr_idx) + ONE);

  a_r7_rd_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && lane_i == 2'd1 && phase == 2'd2) |=> (rd_idx == $past(rd_idx) + ONE) && phase == 2'd0);

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(wr_idx) && $stable(rd_idx) && $stable(mask) && $stable(phase));

  a_r2_reg_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && lane_i != 2'd1) |=> $stable(wr_idx) && $stable(rd_idx) && $stable(mask) && $stable(phase));

  a_r2_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && lane_i == 2'd2) |=> mask == $past(wdata_i));
endmodule

bind clut_host_port clut_host_port_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .lane_i (lane_i),
  .wdata_i(wdata_i),
  .wr_idx (wr_idx_w),
  .rd_idx (rd_idx_w),
  .phase  (phase_w),
  .mask   (mask_w)
);

// File: tb/clut_host_port_test.sv
`timescale 1ns/1ps
module clut_host_port_test;
  localparam int CLK_NS = 20;
  localparam int NV = 26;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  lane_i = 2'd0;
  logic [7:0]  wdata_i = 8'd0, pix_idx_i = 8'd0;
  logic [7:0]  rdata_o;
  logic [23:0] pix_rgb_o;

  int checks = 0, failures = 0;

  always #(CLK_NS/2) clk = ~clk;

  clut_host_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .lane_i(lane_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pix_idx_i(pix_idx_i), .pix_rgb_o(pix_rgb_o)
  );

  // {we, lane, wdata, expected read}
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h10, 8'h00},
    {1'b1, 2'd1, 8'h11, 8'h00}, {1'b1, 2'd1, 8'h22, 8'h00}, {1'b1, 2'd1, 8'h33, 8'h00},
    {1'b1, 2'd1, 8'hA4, 8'h00}, {1'b1, 2'd1, 8'hB5, 8'h00}, {1'b1, 2'd1, 8'hC6, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h12},
    {1'b1, 2'd3, 8'h10, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h11}, {1'b0, 2'd1, 8'h00, 8'h22}, {1'b0, 2'd1, 8'h00, 8'h33},
    {1'b0, 2'd1, 8'h00, 8'hA4}, {1'b0, 2'd1, 8'h00, 8'hB5}, {1'b0, 2'd1, 8'h00, 8'hC6},
    {1'b0, 2'd3, 8'h00, 8'h12},
    {1'b1, 2'd2, 8'h0F, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'h0F},
    {1'b1, 2'd1, 8'hFF, 8'h00}, {1'b1, 2'd1, 8'h3C, 8'h00}, {1'b1, 2'd1, 8'h81, 8'h00},
    {1'b1, 2'd3, 8'h12, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h0F}, {1'b0, 2'd1, 8'h00, 8'h0C}, {1'b0, 2'd1, 8'h00, 8'h01},
    {1'b1, 2'd2, 8'hFF, 8'h00}
  };

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] ln, input logic [7:0] d);
    req_i = 1'b1; we_i = w; lane_i = ln; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ln, output logic [7:0] v);
    acc(1'b0, ln, 8'h00);
    v = rdata_o;
  endtask

  task automatic pix(input logic [7:0] idx, output logic [23:0] v);
    pix_idx_i = idx;
    @(negedge clk);
    v = pix_rgb_o;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  v;
    logic [23:0] p;
    repeat (3) @(negedge clk);
    chk("R1 rdata after reset", {16'h0, rdata_o}, 24'h0);
    chk("R1 pixel after reset", pix_rgb_o, 24'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 write index", {16'h0, v}, 24'h00);
    rd(2'd2, v); chk("R1 mask", {16'h0, v}, 24'hFF);
    rd(2'd3, v); chk("R1 read index", {16'h0, v}, 24'h00);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][18], VEC[i][17:16], VEC[i][15:8]);
      if (!VEC[i][18]) begin
        if (VEC[i][17:16] == 2'd1) chk("R6 data read", {16'h0, rdata_o}, {16'h0, VEC[i][7:0]});
        else                       chk("R2 reg read", {16'h0, rdata_o}, {16'h0, VEC[i][7:0]});
      end
    end

    // R4 / R8 pixel path, incl. masked entry
    pix(8'h10, p); chk("R8 pixel 10", p, 24'h112233);
    pix(8'h11, p); chk("R4 pixel 11", p, 24'hA4B5C6);
    pix(8'h12, p); chk("R4 masked entry", p, 24'h0F0C01);

    // R8 host traffic does not disturb pixel port
    pix_idx_i = 8'h11;
    acc(1'b0, 2'd1, 8'h00);
    acc(1'b1, 2'd0, 8'h40);
    chk("R8 pixel during host", pix_rgb_o, 24'hA4B5C6);

    // R5 write index wrap
    acc(1'b1, 2'd0, 8'hFF);
    acc(1'b1, 2'd1, 8'h01); acc(1'b1, 2'd1, 8'h02); acc(1'b1, 2'd1, 8'h03);
    rd(2'd0, v); chk("R5 write index wrap", {16'h0, v}, 24'h00);
    pix(8'hFF, p); chk("R5 entry FF", p, 24'h010203);

    // R7 read index wrap
    acc(1'b1, 2'd3, 8'hFF);
    rd(2'd1, v); chk("R7 wrap red", {16'h0, v}, 24'h01);
    rd(2'd1, v); chk("R7 wrap green", {16'h0, v}, 24'h02);
    rd(2'd1, v); chk("R7 wrap blue", {16'h0, v}, 24'h03);
    rd(2'd3, v); chk("R7 read index wrap", {16'h0, v}, 24'h00);

    // R9 / R3: interrupted triplet
    acc(1'b1, 2'd0, 8'h20);
    acc(1'b1, 2'd1, 8'hAA); acc(1'b1, 2'd1, 8'hBB); acc(1'b1, 2'd1, 8'hCC);
    acc(1'b1, 2'd0, 8'h20);
    acc(1'b1, 2'd1, 8'h01); acc(1'b1, 2'd1, 8'h02);
    acc(1'b1, 2'd0, 8'h20);
    pix(8'h20, p); chk("R9 partial not committed", p, 24'hAABBCC);
    rd(2'd0, v); chk("R9 write index unchanged", {16'h0, v}, 24'h20);
    acc(1'b1, 2'd1, 8'h44); acc(1'b1, 2'd1, 8'h55); acc(1'b1, 2'd1, 8'h66);
    pix(8'h20, p); chk("R3 restart at red", p, 24'h445566);

    // R3 shared counter cleared by read index write
    acc(1'b1, 2'd3, 8'h20);
    rd(2'd1, v); chk("R6 first of 20", {16'h0, v}, 24'h44);
    acc(1'b1, 2'd3, 8'h10);
    rd(2'd1, v); chk("R3 read restart red", {16'h0, v}, 24'h11);
    rd(2'd1, v); chk("R3 read restart green", {16'h0, v}, 24'h22);
    rd(2'd1, v); chk("R3 read restart blue", {16'h0, v}, 24'h33);
    rd(2'd3, v); chk("R7 read index step", {16'h0, v}, 24'h11);

    // R2 idle cycles and register reads leave state alone
    repeat (3) @(negedge clk);
    rd(2'd2, v); rd(2'd0, v); chk("R2 write index held", {16'h0, v}, 24'h21);
    rd(2'd1, v); chk("R2 counter untouched", {16'h0, v}, 24'hA4);

    finish_run();
  end
endmodule